// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches 28 external interrupt pins and turns activity on them into four interrupt requests for a parent interrupt controller. Every pin passes through a two-flop synchronizer and then a trigger detector whose mode (one of two active levels or one of three edge kinds) comes from a small trigger-configuration field. Each pair of neighbouring pins shares one such field. A detected trigger sets a sticky pending bit. Software clears a pending bit by writing a 1 to it.

A mask bit per line decides whether that line's pending bit can reach its group output. Masking does not stop the pending bit from being set. The four group outputs cover lines 0–3, 4–11, 12–19 and 20–27. Each group is the OR of the unmasked pending bits of its lines. This lets the interrupt handler learn which group fired, then read the pending register to find the line.

Software reaches four registers through a single-cycle synchronous bus. A write takes effect at the clock edge. A read is combinational on the register select.

Top module: `ext_irq_grouper`

## Requirements
- R1: While reset is held and directly after it, every mask bit is 1, every pending bit is 0, both trigger-configuration registers read 0 and all four group outputs are low.
- R2: Register select 0 addresses the trigger configuration of lines 0–15, select 1 that of lines 16–27, select 2 the mask and select 3 the pending bits. A write with wrEn high takes effect at the clock edge. rdData shows the selected register in the same cycle.
- R3: Line i below 16 takes its mode from select-0 bits [(i/2)*4 +: 3]. Line i from 16 to 27 takes its mode from select-1 bits [((i-16)/2)*4 +: 3]. Both lines of a pair use the same field. All other bits of the two configuration registers ignore writes and read 0 (select 0 reads at most 0x77777777, select 1 at most 0x00777777).
- R4: Mode encoding: 000 is active-low level, 001 is active-high level, 01x is falling edge, 10x is rising edge, 11x is both edges. Edges are judged between successive synchronized samples.
- R5: A pin change sets the pending bit at the third rising clock edge after the change is applied, and not before.
- R6: In a level mode the pending bit is set again on every cycle the synchronized level is active. A clear has no lasting effect until the level is gone.
- R7: In an edge mode the pending bit stays set after the pin returns, until it is cleared.
- R8: Writing select 3 clears every pending bit whose write-data bit is 1. Bits written 0 are left unchanged.
- R9: If a clear and a trigger event reach the same line in the same cycle, the pending bit stays set.
- R10: A masked line still sets its pending bit, but that bit does not drive its group output.
- R11: irqGroup[0] covers lines 0–3, [1] lines 4–11, [2] lines 12–19 and [3] lines 20–27. Each is the OR of pending AND NOT mask over its lines, and follows the pending and mask bits in the same cycle.
- R12: No line exists above 27: bits 31:28 of the mask and pending registers always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| extPins | input | 28 | Asynchronous external interrupt pins |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 cfg low, 1 cfg high, 2 mask, 3 pending) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the selected register |
| irqGroup | output | 4 | Grouped interrupt requests |

## Verification
The bench aims at the collision of a clear with a new event on the same line. A design that gave the clear priority would drop an interrupt there. It also checks the exact three-edge latency: an off-by-one synchronizer would set pending one edge early or late. It clears level-mode lines while the level is still active, where a design without re-assertion would lose a live request. It sets pending on masked lines, where a mask applied before the latch would leave pending at 0. It also drives both lines of a shared field and lines at the unequal group borders (3/4, 11/12, 19/20), where a wrong field offset or group range would credit the wrong line or group.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int LINES       = 28;
  localparam int DW          = 32;
  localparam int FIELD_W     = 3;
  localparam int FIELD_PITCH = 4;
  localparam int LO_LINES    = 16;
  localparam int NUM_GROUPS  = 4;
  localparam int SEL_W       = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CFG_LO = 2'd0,
    SEL_CFG_HI = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_PEND   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic cfgLoWr;
    logic cfgHiWr;
    logic maskWr;
    logic pendClr;
  } regStrobe_t;

  function automatic int groupLo(int g);
    return (g == 0) ? 0 : (g * 8 - 4);
  endfunction

  function automatic int groupHi(int g);
    return g * 8 + 3;
  endfunction

  function automatic logic [DW-1:0] fieldKeep(int nFields);
    logic [DW-1:0] k;
    k = '0;
    for (int f = 0; f < DW / FIELD_PITCH; f++)
      if (f < nFields) k[f*FIELD_PITCH +: FIELD_W] = '1;
    return k;
  endfunction
endpackage

// File: rtl/extirq_trig.sv
module extirq_trig
  import extirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               pinIn,
  input  logic [FIELD_W-1:0] mode,
  output logic               evt
);
  logic syncA, syncB, prevB;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  always_comb begin
    case (mode[2:1])
      2'b00:   evt = mode[0] ? syncB : ~syncB;
      2'b01:   evt = prevB & ~syncB;
      2'b10:   evt = syncB & ~prevB;
      default: evt = syncB ^ prevB;
    endcase
  end
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] regSel,
  output regStrobe_t       strobe
);
  always_comb begin
    strobe         = '0;
    strobe.cfgLoWr = wrEn && (regSel == SEL_CFG_LO);
    strobe.cfgHiWr = wrEn && (regSel == SEL_CFG_HI);
    strobe.maskWr  = wrEn && (regSel == SEL_MASK);
    strobe.pendClr = wrEn && (regSel == SEL_PEND);
  end

  // R2: one register at most is written per cycle
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));
endmodule

// File: rtl/extirq_datapath.sv
module extirq_datapath
  import extirq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LINES-1:0]      extPins,
  input  regStrobe_t            strobe,
  input  logic [DW-1:0]         wrData,
  input  logic [SEL_W-1:0]      regSel,
  output logic [DW-1:0]         rdData,
  output logic [NUM_GROUPS-1:0] irqGroup
);
  localparam int HI_LINES = LINES - LO_LINES;
  localparam logic [DW-1:0] CFG_LO_KEEP = fieldKeep(LO_LINES / 2);
  localparam logic [DW-1:0] CFG_HI_KEEP = fieldKeep((HI_LINES + 1) / 2);

  logic [DW-1:0]    cfgLoQ, cfgHiQ;
  logic [LINES-1:0] maskQ, pendQ, evt, clrBits, active;
  logic [FIELD_W-1:0] lineMode [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgLoQ <= '0;
      cfgHiQ <= '0;
      maskQ  <= '1;
    end else begin
      if (strobe.cfgLoWr) cfgLoQ <= wrData & CFG_LO_KEEP;
      if (strobe.cfgHiWr) cfgHiQ <= wrData & CFG_HI_KEEP;
      if (strobe.maskWr)  maskQ  <= wrData[LINES-1:0];
    end
  end

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_line
      localparam int OFF = (i < LO_LINES) ? (i / 2) * FIELD_PITCH
                                          : ((i - LO_LINES) / 2) * FIELD_PITCH;
      if (i < LO_LINES) begin : g_lo
        assign lineMode[i] = cfgLoQ[OFF +: FIELD_W];
      end else begin : g_hi
        assign lineMode[i] = cfgHiQ[OFF +: FIELD_W];
      end
      extirq_trig u_trig (
        .clk   (clk),
        .rst   (rst),
        .pinIn (extPins[i]),
        .mode  (lineMode[i]),
        .evt   (evt[i])
      );
    end
  endgenerate

  assign clrBits = strobe.pendClr ? wrData[LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) pendQ <= '0;
    else     pendQ <= (pendQ & ~clrBits) | evt;
  end

  assign active = pendQ & ~maskQ;

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam int GLO = groupLo(g);
      localparam int GHI = groupHi(g);
      assign irqGroup[g] = |active[GHI:GLO];
    end
  endgenerate

  always_comb begin
    case (regSel)
      SEL_CFG_LO: rdData = cfgLoQ;
      SEL_CFG_HI: rdData = cfgHiQ;
      SEL_MASK:   rdData = {{(DW-LINES){1'b0}}, maskQ};
      default:    rdData = {{(DW-LINES){1'b0}}, pendQ};
    endcase
  end

  // R1: reset leaves every line masked and nothing pending
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (maskQ == '1 && pendQ == '0));

  // R5: a pending bit only rises when its detector reported an event
  p_pend_rise_cause_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pendQ & ~$past(pendQ) & ~$past(evt)) == '0));

  // R8: a pending bit only falls under a clear write of that bit
  p_pend_fall_clear_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pendQ) & ~pendQ & ~$past(clrBits)) == '0));

  // R9: an event always leaves its pending bit set, clear or not
  p_event_wins_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pendQ & $past(evt)) == $past(evt)));

  // R10: with every line masked no group may be raised
  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (maskQ == '1) |-> (irqGroup == '0));
endmodule

// File: rtl/ext_irq_grouper.sv
module ext_irq_grouper
  import extirq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LINES-1:0]      extPins,
  input  logic                  wrEn,
  input  logic [SEL_W-1:0]      regSel,
  input  logic [DW-1:0]         wrData,
  output logic [DW-1:0]         rdData,
  output logic [NUM_GROUPS-1:0] irqGroup
);
  regStrobe_t strobe;

  extirq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .regSel (regSel),
    .strobe (strobe)
  );

  extirq_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .extPins  (extPins),
    .strobe   (strobe),
    .wrData   (wrData),
    .regSel   (regSel),
    .rdData   (rdData),
    .irqGroup (irqGroup)
  );
endmodule

// File: tb/tb_ext_irq_grouper.sv
`timescale 1ns/1ps
module tb_ext_irq_grouper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [27:0] extPins = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  regSel = 2'd3;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  irqGroup;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_irq_grouper dut (
    .clk(clk), .rst(rst), .extPins(extPins), .wrEn(wrEn),
    .regSel(regSel), .wrData(wrData), .rdData(rdData), .irqGroup(irqGroup)
  );

  // bench model of the requirements
  logic [27:0] mPend, mMask, mS1, mS2, mPrev;
  logic [31:0] mCfgLo, mCfgHi;
  logic [27:0] p;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] mMode(int i);
    if (i < 16) return mCfgLo[(i/2)*4 +: 3];
    return mCfgHi[((i-16)/2)*4 +: 3];
  endfunction

  function automatic logic mEvt(int i);
    logic [2:0] m;
    m = mMode(i);
    if (m == 3'b000) return !mS2[i];
    if (m == 3'b001) return mS2[i];
    if (m[2:1] == 2'b01) return mPrev[i] & !mS2[i];
    if (m[2:1] == 2'b10) return mS2[i] & !mPrev[i];
    return mS2[i] ^ mPrev[i];
  endfunction

  function automatic logic [31:0] mGroups();
    logic [27:0] a;
    logic [31:0] gr;
    a = mPend & ~mMask;
    gr = '0;
    gr[0] = |a[3:0];
    gr[1] = |a[11:4];
    gr[2] = |a[19:12];
    gr[3] = |a[27:20];
    return gr;
  endfunction

  task automatic modelTick(logic [27:0] pins, logic we, logic [1:0] sel, logic [31:0] wd);
    logic [27:0] ev, clr;
    for (int i = 0; i < 28; i++) ev[i] = mEvt(i);
    clr = (we && sel == 2'd3) ? wd[27:0] : '0;
    mPend = (mPend & ~clr) | ev;
    mPrev = mS2;
    mS2 = mS1;
    mS1 = pins;
    if (we) begin
      case (sel)
        2'd0: mCfgLo = wd & 32'h7777_7777;
        2'd1: mCfgHi = wd & 32'h0077_7777;
        2'd2: mMask = wd[27:0];
        default: ;
      endcase
    end
  endtask

  // called at a negative edge; leaves regSel on the pending register
  task automatic step(logic we, logic [1:0] sel, logic [31:0] wd, string tag);
    extPins = p; wrEn = we; regSel = sel; wrData = wd;
    @(posedge clk);
    modelTick(p, we, sel, wd);
    @(negedge clk);
    wrEn = 1'b0; regSel = 2'd3;
    #0.5;
    chk({tag, " R11 pending vs model"}, rdData, {4'b0, mPend});
    chk({tag, " R11 groups vs model"}, {28'b0, irqGroup}, mGroups());
  endtask

  task automatic rd(logic [1:0] sel, logic [31:0] exp, string tag);
    regSel = sel;
    #0.5;
    chk(tag, rdData, exp);
    regSel = 2'd3;
    #0.5;
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    p = '0;
    mPend = '0; mMask = '1; mS1 = '0; mS2 = '0; mPrev = '0;
    mCfgLo = '0; mCfgHi = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    rd(2'd0, 32'h0, "R1 cfg low at reset");
    rd(2'd1, 32'h0, "R1 cfg high at reset");
    rd(2'd2, 32'h0FFF_FFFF, "R1 mask at reset");
    rd(2'd3, 32'h0, "R1 pending at reset");
    chk("R1 groups at reset", {28'b0, irqGroup}, 32'h0);
    rst = 1'b0;

    // R3 only field bits are stored
    step(1'b1, 2'd0, 32'hFFFF_FFFF, "R3");
    rd(2'd0, 32'h7777_7777, "R3 cfg low keeps field bits");
    step(1'b1, 2'd1, 32'hFFFF_FFFF, "R3");
    rd(2'd1, 32'h0077_7777, "R3 cfg high keeps field bits");

    // all rising, clear everything
    step(1'b1, 2'd0, 32'h4444_4444, "R2");
    step(1'b1, 2'd1, 32'h0044_4444, "R2");
    step(1'b1, 2'd3, 32'hFFFF_FFFF, "R8");
    chk("R8 all pending cleared", rdData, 32'h0);
    step(1'b1, 2'd2, 32'hFFFF_FFFF, "R12");
    rd(2'd2, 32'h0FFF_FFFF, "R12 mask top bits read 0");
    step(1'b1, 2'd2, 32'h0, "R2");
    rd(2'd2, 32'h0, "R2 mask written");

    // R5 latency, line 5 rising
    p[5] = 1'b1;
    step(1'b0, 2'd0, 0, "R5");
    chk("R5 not after 1 edge", {31'b0, rdData[5]}, 0);
    step(1'b0, 2'd0, 0, "R5");
    chk("R5 not after 2 edges", {31'b0, rdData[5]}, 0);
    step(1'b0, 2'd0, 0, "R5");
    chk("R5 set after 3 edges", {31'b0, rdData[5]}, 1);
    chk("R11 line 5 in group 1", {28'b0, irqGroup}, 32'h2);

    // R7 sticky edge
    p[5] = 1'b0;
    repeat (4) step(1'b0, 2'd0, 0, "R7");
    chk("R7 edge pending sticky", {31'b0, rdData[5]}, 1);
    step(1'b1, 2'd3, 32'h0, "R8");
    chk("R8 write 0 keeps bit", {31'b0, rdData[5]}, 1);
    step(1'b1, 2'd3, 32'h20, "R8");
    chk("R8 write 1 clears bit", {31'b0, rdData[5]}, 0);

    // R9 clear collides with event on line 6
    p[6] = 1'b1;
    step(1'b0, 2'd0, 0, "R9");
    step(1'b0, 2'd0, 0, "R9");
    step(1'b1, 2'd3, 32'h40, "R9");
    chk("R9 event beats clear", {31'b0, rdData[6]}, 1);
    step(1'b1, 2'd3, 32'h40, "R9");
    chk("R9 later clear works", {31'b0, rdData[6]}, 0);

    // R6 high level on line 16
    step(1'b1, 2'd1, 32'h0044_4441, "R6");
    p[16] = 1'b1;
    repeat (3) step(1'b0, 2'd0, 0, "R6");
    chk("R6 level sets pending", {31'b0, rdData[16]}, 1);
    step(1'b1, 2'd3, 32'h1_0000, "R6");
    chk("R6 clear while active ineffective", {31'b0, rdData[16]}, 1);
    p[16] = 1'b0;
    repeat (3) step(1'b0, 2'd0, 0, "R6");
    step(1'b1, 2'd3, 32'h1_0000, "R6");
    chk("R6 clear after level gone", {31'b0, rdData[16]}, 0);

    // R10 masked line 20
    step(1'b1, 2'd2, 32'h10_0000, "R10");
    p[20] = 1'b1;
    repeat (3) step(1'b0, 2'd0, 0, "R10");
    chk("R10 masked line still pends", {31'b0, rdData[20]}, 1);
    chk("R10 masked line no group", {31'b0, irqGroup[3]}, 0);
    step(1'b1, 2'd2, 32'h0, "R11");
    chk("R11 group 3 after unmask", {31'b0, irqGroup[3]}, 1);
    step(1'b1, 2'd3, 32'h0FFF_FFFF, "R8");

    // R4 falling on line 24 (cfg high field 4)
    p[24] = 1'b1;
    repeat (3) step(1'b0, 2'd0, 0, "R4");
    step(1'b1, 2'd1, 32'h0042_4441, "R4");
    step(1'b1, 2'd3, 32'h0FFF_FFFF, "R4");
    p[24] = 1'b0;
    repeat (3) step(1'b0, 2'd0, 0, "R4");
    chk("R4 falling edge sets line 24", {31'b0, rdData[24]}, 1);
    chk("R3 shared field line 25 quiet", {31'b0, rdData[25]}, 0);

    // R4 both edges on line 0
    step(1'b1, 2'd0, 32'h4444_4446, "R4");
    p[0] = 1'b1;
    repeat (3) step(1'b0, 2'd0, 0, "R4");
    chk("R4 both edges rise", {31'b0, rdData[0]}, 1);
    step(1'b1, 2'd3, 32'h1, "R4");
    p[0] = 1'b0;
    repeat (3) step(1'b0, 2'd0, 0, "R4");
    chk("R4 both edges fall", {31'b0, rdData[0]}, 1);
    chk("R11 line 0 in group 0", {31'b0, irqGroup[0]}, 1);

    // R4 low level on lines 12/13 (field 6)
    step(1'b1, 2'd0, 32'h4044_4446, "R4");
    step(1'b0, 2'd0, 0, "R4");
    chk("R4 low level pair", {30'b0, rdData[13:12]}, 32'h3);

    // random phase
    for (int n = 0; n < 500; n++) begin
      logic we;
      logic [1:0] sel;
      if ($urandom_range(0, 3) == 0) p[$urandom_range(0, 27)] ^= 1'b1;
      we = ($urandom_range(0, 9) < 3);
      sel = 2'($urandom_range(0, 3));
      step(we, sel, $urandom, "R11 random");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule